// File: doc/BRIEF.md
# Indexed Vector Multiply-Accumulate Unit

This unit runs one indexed multiply-add or multiply-subtract over a scalable signed integer vector. A 32-bit instruction word is presented with a `start` strobe. The unit decodes the accumulator register, the first source register, the indexed source register, the element width, the lane index and the add/subtract selector. It then walks the vector one 128-bit segment per clock. For each segment it reads the accumulator, the first source and the indexed source through three combinational read ports, and it writes the updated accumulator segment back through one write port in the same cycle.

The second multiplicand is not taken lane by lane. Inside every 128-bit segment, one element of the indexed register is chosen by the immediate index, and every lane of that segment multiplies by that shared element. Products are formed at double width and cut to the element width. The add or subtract then wraps modulo 2^esize. Every lane is updated; there is no masking.

The sequencer has three states. `ST_IDLE` waits for `start`. A legal word moves it to `ST_RUN` (transition *launch*). An illegal word leaves it in `ST_IDLE` and pulses `undef` (transition *reject*). `ST_RUN` steps the segment counter each cycle (transition *step*) and, after the last segment, moves to `ST_FIN` (transition *drain*). `ST_FIN` raises `done` for one cycle and returns to `ST_IDLE` (transition *retire*).

Top module: `idx_mac_unit`

## Requirements
- R1: The destination/accumulator register is instruction bits [4:0] and the first source register is bits [9:5]; only the destination register is written.
- R2: Size code bits [23:22] select the element width: 00 and 01 give 16-bit, 10 gives 32-bit, 11 gives 64-bit.
- R3: Bit 10 clear gives dest = dest + a*b; bit 10 set gives dest = dest - a*b.
- R4: For 16-bit elements the indexed register is bits [18:16] and the index is {bit 22, bits [20:19]}.
- R5: For 32-bit elements the indexed register is bits [18:16] and the index is bits [20:19].
- R6: For 64-bit elements the indexed register is bits [19:16] and the index is bit 20.
- R7: Lane i multiplies by the indexed-register element at position (first lane of i's 128-bit segment) + index.
- R8: Elements are signed. The product is truncated to the element width and the result wraps with no saturation. Every lane is written and an accumulator that is also a source (register aliasing) uses its old value.
- R9: After an accepted `start`, segment s (0 upward) is written in cycle s+1. `done` is high for exactly one cycle, in cycle VL/128+1.
- R10: A word with bits [31:24] not equal to 0x44, bit 21 clear, or bits [15:11] not equal to 00001 is rejected: `undef` pulses one cycle after `start`, no write occurs and `done` stays low.
- R11: After reset `busy`, `done`, `undef`, `rd_en` and `wr_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Accept `instr` while idle |
| instr | input | 32 | Instruction word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| undef | output | 1 | One-cycle illegal-word pulse |
| rd_en | output | 1 | Read ports active |
| rd_seg | output | SEG_AW | Segment number for reads |
| rd_acc_addr | output | 5 | Accumulator read register |
| rd_src_addr | output | 5 | First source read register |
| rd_idx_addr | output | 5 | Indexed source read register |
| acc_data | input | 128 | Accumulator segment data |
| src_data | input | 128 | First source segment data |
| idx_data | input | 128 | Indexed source segment data |
| wr_en | output | 1 | Write strobe |
| wr_addr | output | 5 | Write register |
| wr_seg | output | SEG_AW | Segment number for the write |
| wr_data | output | 128 | Updated accumulator segment |

## Verification
From the ports, the hardest case to reach is each index value paired with the element width whose field layout gives it meaning. At 16-bit width the top index bit shares instruction bit 22 with the size code, so size code 01 is only exercised by indices 4 to 7. The bench therefore sweeps every index of every width in both add and subtract mode. It builds each word from its fields so that both 16-bit size codes appear. Register fills alternate between random data and extreme values (0x8000, 0x7FFF, 0xFFFF), which forces sign handling and wrap-around in the truncated product. One run aliases all three registers.

// File: rtl/idx_mac_pkg.sv
package idx_mac_pkg;
    localparam int SEG_BITS = 128;

    // fixed opcode bits of the indexed multiply-accumulate group
    localparam logic [31:0] GRP_MASK  = 32'hFF20_F800;
    localparam logic [31:0] GRP_MATCH = 32'h4420_0800;

    typedef enum logic [1:0] {
        ESZ_H = 2'd0,
        ESZ_S = 2'd1,
        ESZ_D = 2'd2
    } esz_e;

    typedef struct packed {
        logic [4:0] acc_reg;
        logic [4:0] src_reg;
        logic [4:0] idx_reg;
        esz_e       esz;
        logic [2:0] lane_idx;
        logic       sub;
    } mac_ctl_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } mac_state_e;
endpackage

// File: rtl/idx_mac_decode.sv
module idx_mac_decode
    import idx_mac_pkg::*;
(
    input  logic [31:0] instr,
    output mac_ctl_t    ctl,
    output logic        legal
);
    always_comb begin
        legal        = ((instr & GRP_MASK) == GRP_MATCH);
        ctl.acc_reg  = instr[4:0];
        ctl.src_reg  = instr[9:5];
        ctl.sub      = instr[10];
        unique case (instr[23:22])
            2'b00, 2'b01: begin
                ctl.esz      = ESZ_H;
                ctl.idx_reg  = {2'b00, instr[18:16]};
                ctl.lane_idx = {instr[22], instr[20:19]};
            end
            2'b10: begin
                ctl.esz      = ESZ_S;
                ctl.idx_reg  = {2'b00, instr[18:16]};
                ctl.lane_idx = {1'b0, instr[20:19]};
            end
            default: begin
                ctl.esz      = ESZ_D;
                ctl.idx_reg  = {1'b0, instr[19:16]};
                ctl.lane_idx = {2'b00, instr[20]};
            end
        endcase
    end
endmodule

// File: rtl/idx_mac_lanes.sv
module idx_mac_lanes
    import idx_mac_pkg::*;
(
    input  esz_e                esz,
    input  logic [2:0]          lane_idx,
    input  logic                sub,
    input  logic [SEG_BITS-1:0] acc_seg,
    input  logic [SEG_BITS-1:0] src_seg,
    input  logic [SEG_BITS-1:0] mul_seg,
    output logic [SEG_BITS-1:0] res_seg
);
    localparam int NWID = 3;

    logic [SEG_BITS-1:0] res_w [NWID];

    for (genvar g = 0; g < NWID; g++) begin : g_wid
        localparam int W  = 16 << g;
        localparam int LN = SEG_BITS / W;
        localparam int IW = $clog2(LN);

        logic [W-1:0] shared_op;
        assign shared_op = mul_seg[int'(lane_idx[IW-1:0]) * W +: W];

        for (genvar l = 0; l < LN; l++) begin : g_lane
            logic signed [2*W-1:0] prod;
            logic        [W-1:0]   acc_e;
            assign acc_e = acc_seg[l*W +: W];
            assign prod  = $signed(src_seg[l*W +: W]) * $signed(shared_op);
            assign res_w[g][l*W +: W] = sub ? (acc_e - prod[W-1:0])
                                            : (acc_e + prod[W-1:0]);
        end
    end

    always_comb begin
        unique case (esz)
            ESZ_H:   res_seg = res_w[0];
            ESZ_S:   res_seg = res_w[1];
            default: res_seg = res_w[2];
        endcase
    end
endmodule

// File: rtl/idx_mac_unit.sv
module idx_mac_unit
    import idx_mac_pkg::*;
#(
    parameter int VL_BITS = 512,
    localparam int NSEG   = VL_BITS / SEG_BITS,
    localparam int SEG_AW = (NSEG > 1) ? $clog2(NSEG) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [31:0]         instr,
    output logic                busy,
    output logic                done,
    output logic                undef,
    output logic                rd_en,
    output logic [SEG_AW-1:0]   rd_seg,
    output logic [4:0]          rd_acc_addr,
    output logic [4:0]          rd_src_addr,
    output logic [4:0]          rd_idx_addr,
    input  logic [SEG_BITS-1:0] acc_data,
    input  logic [SEG_BITS-1:0] src_data,
    input  logic [SEG_BITS-1:0] idx_data,
    output logic                wr_en,
    output logic [4:0]          wr_addr,
    output logic [SEG_AW-1:0]   wr_seg,
    output logic [SEG_BITS-1:0] wr_data
);
    localparam logic [SEG_AW-1:0] LAST_SEG = SEG_AW'(NSEG - 1);

    mac_state_e        state_q, state_d;
    logic [SEG_AW-1:0] seg_q, seg_d;
    mac_ctl_t          ctl_q, ctl_d;
    logic              undef_q, undef_d;
    mac_ctl_t          dec_ctl;
    logic              dec_legal;

    idx_mac_decode u_dec (
        .instr (instr),
        .ctl   (dec_ctl),
        .legal (dec_legal)
    );

    idx_mac_lanes u_lanes (
        .esz      (ctl_q.esz),
        .lane_idx (ctl_q.lane_idx),
        .sub      (ctl_q.sub),
        .acc_seg  (acc_data),
        .src_seg  (src_data),
        .mul_seg  (idx_data),
        .res_seg  (wr_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            seg_q   <= '0;
            ctl_q   <= '0;
            undef_q <= 1'b0;
        end else begin
            state_q <= state_d;
            seg_q   <= seg_d;
            ctl_q   <= ctl_d;
            undef_q <= undef_d;
        end
    end

    // transitions: launch, reject, step, drain, retire
    always_comb begin
        state_d = state_q;
        seg_d   = seg_q;
        ctl_d   = ctl_q;
        undef_d = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (dec_legal) begin
                        ctl_d   = dec_ctl;
                        seg_d   = '0;
                        state_d = ST_RUN;
                    end else begin
                        undef_d = 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (seg_q == LAST_SEG) state_d = ST_FIN;
                else                   seg_d   = seg_q + 1'b1;
            end
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_en = 1'b0;
        wr_en = 1'b0;
        busy  = 1'b0;
        done  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN: begin
                rd_en = 1'b1;
                wr_en = 1'b1;
                busy  = 1'b1;
            end
            ST_FIN: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: ;
        endcase
        undef       = undef_q;
        rd_seg      = seg_q;
        wr_seg      = seg_q;
        rd_acc_addr = ctl_q.acc_reg;
        rd_src_addr = ctl_q.src_reg;
        rd_idx_addr = ctl_q.idx_reg;
        wr_addr     = ctl_q.acc_reg;
    end
endmodule

// File: rtl/idx_mac_chk.sv
module idx_mac_chk #(
    parameter int SEG_AW = 2,
    parameter int NSEG   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              undef,
    input logic              wr_en,
    input logic [4:0]        wr_addr,
    input logic [SEG_AW-1:0] wr_seg
);
    localparam logic [SEG_AW-1:0] LAST = SEG_AW'(NSEG - 1);

    a_r9_write_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy);

    a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(wr_en) && ($past(wr_seg) == LAST)));

    a_r9_segment_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_seg == SEG_AW'($past(wr_seg) + 1'b1)));

    a_r1_dest_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> $stable(wr_addr));

    a_r10_undef_idle: assert property (@(posedge clk) disable iff (!rst_n)
        undef |-> (!busy && !wr_en && !done));
endmodule

bind idx_mac_unit idx_mac_chk #(.SEG_AW(SEG_AW), .NSEG(NSEG)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .undef   (undef),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_seg  (wr_seg)
);

// File: tb/idx_mac_unit_tb_top.sv
module idx_mac_unit_tb_top;
    localparam int VL   = 512;
    localparam int NSEG = VL / 128;
    localparam int SAW  = $clog2(NSEG);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [31:0] instr = '0;
    logic busy, done, undef, rd_en, wr_en;
    logic [SAW-1:0] rd_seg, wr_seg;
    logic [4:0] rd_acc_addr, rd_src_addr, rd_idx_addr, wr_addr;
    logic [127:0] acc_data, src_data, idx_data, wr_data;

    logic [VL-1:0] rf   [32];
    logic [VL-1:0] snap [32];
    logic          fill_req = 1'b0;
    logic [4:0]    fill_reg = '0;
    logic [VL-1:0] fill_val = '0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    idx_mac_unit #(.VL_BITS(VL)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .busy(busy), .done(done), .undef(undef),
        .rd_en(rd_en), .rd_seg(rd_seg),
        .rd_acc_addr(rd_acc_addr), .rd_src_addr(rd_src_addr), .rd_idx_addr(rd_idx_addr),
        .acc_data(acc_data), .src_data(src_data), .idx_data(idx_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_seg(wr_seg), .wr_data(wr_data)
    );

    assign acc_data = rf[rd_acc_addr][int'(rd_seg)*128 +: 128];
    assign src_data = rf[rd_src_addr][int'(rd_seg)*128 +: 128];
    assign idx_data = rf[rd_idx_addr][int'(rd_seg)*128 +: 128];

    always @(posedge clk) begin
        if (fill_req) rf[fill_reg] <= fill_val;
        else if (wr_en) rf[wr_addr][int'(wr_seg)*128 +: 128] <= wr_data;
    end

    task automatic check(input bit ok, input string tag, input logic [VL-1:0] act,
                         input logic [VL-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic fill(input int mode);
        for (int r = 0; r < 32; r++) begin
            logic [VL-1:0] v;
            for (int c = 0; c < VL/16; c++) begin
                logic [15:0] h;
                if (mode == 0) h = 16'($urandom);
                else begin
                    case ((c + r) % 4)
                        0: h = 16'h8000;
                        1: h = 16'h7FFF;
                        2: h = 16'hFFFF;
                        default: h = 16'h0001;
                    endcase
                end
                v[c*16 +: 16] = h;
            end
            @(negedge clk);
            fill_req = 1'b1; fill_reg = 5'(r); fill_val = v;
        end
        @(negedge clk);
        fill_req = 1'b0;
        for (int r = 0; r < 32; r++) snap[r] = rf[r];
    endtask

    // width code: 0 -> 16, 1 -> 32, 2 -> 64
    function automatic logic [31:0] mk(input int wc, input bit sub, input int zda,
                                       input int zn, input int zm, input int idx);
        logic [31:0] w = 32'h4420_0800;
        w[4:0] = 5'(zda); w[9:5] = 5'(zn); w[10] = sub;
        case (wc)
            0: begin w[23:22] = {1'b0, idx[2]}; w[18:16] = 3'(zm); w[20:19] = idx[1:0]; end
            1: begin w[23:22] = 2'b10; w[18:16] = 3'(zm); w[20:19] = idx[1:0]; end
            default: begin w[23:22] = 2'b11; w[19:16] = 4'(zm); w[20] = idx[0]; end
        endcase
        return w;
    endfunction

    function automatic logic [VL-1:0] model(input logic [VL-1:0] acc, input logic [VL-1:0] a,
                                            input logic [VL-1:0] m, input int w,
                                            input int idx, input bit sub);
        logic [VL-1:0] out = '0;
        logic [63:0] mask = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
        int per = 128 / w;
        for (int i = 0; i < VL / w; i++) begin
            int base = i - (i % per);
            logic [63:0] ae, be, ce, p, r;
            ae = 64'(a >> (i * w)) & mask;
            be = 64'(m >> ((base + idx) * w)) & mask;
            ce = 64'(acc >> (i * w)) & mask;
            if (w < 64) begin // sign-extend to 64 bits
                if (ae[w-1]) ae = ae | ~mask;
                if (be[w-1]) be = be | ~mask;
            end
            p = ae * be;
            r = (sub ? (ce - p) : (ce + p)) & mask;
            for (int b = 0; b < w; b++) out[i*w + b] = r[b];
        end
        return out;
    endfunction

    task automatic run_op(input int wc, input bit sub, input int zda, input int zn,
                          input int zm, input int idx, input string tag);
        logic [VL-1:0] exp;
        int lat = 0;
        bit others_ok = 1'b1;
        int w = 16 << wc;
        exp = model(snap[zda], snap[zn], snap[zm], w, idx, sub);
        @(negedge clk);
        instr = mk(wc, sub, zda, zn, zm, idx);
        start = 1'b1;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            start = 1'b0;
            if (done) begin lat = k; break; end
        end
        check(lat == NSEG + 1, {"R9 latency ", tag}, VL'(lat), VL'(NSEG + 1));
        check(rf[zda] === exp, {tag, " R3 R7 R8 dest"}, rf[zda], exp);
        for (int r = 0; r < 32; r++)
            if (r != zda && rf[r] !== snap[r]) others_ok = 1'b0;
        check(others_ok, {"R1 only dest written ", tag}, VL'(others_ok), VL'(1));
        @(negedge clk);
        for (int r = 0; r < 32; r++) snap[r] = rf[r];
    endtask

    task automatic run_bad(input logic [31:0] word, input string tag);
        bit seen_done = 1'b0;
        bit same = 1'b1;
        @(negedge clk);
        instr = word;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(undef === 1'b1 && busy === 1'b0, {"R10 undef pulse ", tag},
              VL'({undef, busy}), VL'(2'b10));
        @(negedge clk);
        check(undef === 1'b0, {"R10 undef one cycle ", tag}, VL'(undef), VL'(0));
        for (int k = 0; k < NSEG + 3; k++) begin
            if (done || wr_en) seen_done = 1'b1;
            @(negedge clk);
        end
        for (int r = 0; r < 32; r++) if (rf[r] !== snap[r]) same = 1'b0;
        check(!seen_done && same, {"R10 no write or done ", tag},
              VL'({seen_done, same}), VL'(2'b01));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] good;
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        // R11 reset state
        check({busy, done, undef, rd_en, wr_en} === 5'b0, "R11 reset outputs",
              VL'({busy, done, undef, rd_en, wr_en}), VL'(0));
        rst_n = 1'b1;
        fill(0);

        // R2 R4: 16-bit, every index (both size codes), both ops
        for (int sub = 0; sub < 2; sub++)
            for (int idx = 0; idx < 8; idx++)
                run_op(0, sub[0], (idx * 7 + 3) % 32, (idx * 5 + 1) % 32, (idx * 3) % 8, idx,
                       "R2 R4 h");
        // R5: 32-bit
        for (int sub = 0; sub < 2; sub++)
            for (int idx = 0; idx < 4; idx++)
                run_op(1, sub[0], (idx * 11 + 2) % 32, (idx * 9 + 4) % 32, (idx * 5 + 2) % 8, idx,
                       "R2 R5 s");
        // R6: 64-bit, indexed registers above 7
        for (int sub = 0; sub < 2; sub++)
            for (int idx = 0; idx < 2; idx++)
                run_op(2, sub[0], 20 + idx, 6 + sub * 3, 9 + idx * 5, idx, "R2 R6 d");

        // R8: extreme values for sign handling and wrap
        fill(1);
        for (int wc = 0; wc < 3; wc++)
            for (int sub = 0; sub < 2; sub++)
                run_op(wc, sub[0], 12 + wc, 1 + wc, 2 + wc, wc == 2 ? 1 : 3 - wc, "R8 extreme");
        // R8: aliasing of all three registers
        run_op(1, 1'b0, 5, 5, 5, 2, "R8 alias");

        // R10: illegal encodings
        good = mk(1, 1'b0, 3, 4, 5, 1);
        run_bad(good ^ 32'h8000_0000, "top byte");
        run_bad(good & ~32'h0020_0000, "bit21");
        run_bad(good & ~32'h0000_0800, "bit11");
        run_op(1, 1'b0, 3, 4, 5, 1, "R10 legal after reject");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule